// File: doc/BRIEF.md
# Bus Idle Signal-Free Timer

This block decides when a transceiver on a shared single-wire bus may begin a new frame. A bus that has just carried a frame must stay quiet for a minimum time before anyone drives it again. The block counts that quiet time in half-bit ticks and raises a `bus_free` qualifier once enough time has passed. The transmitter holds its first bit until it sees that qualifier.

The required quiet time comes from a 3-bit code. A non-zero code n asks for 0.5 + (n − 1) nominal bit periods, which is 2n − 1 half-bit ticks. Code 0 selects a default instead, and that default has two values given as parameters: a longer one for a device that is starting a new frame and a shorter one for a retransmission. A `retry` input chooses between them.

A mode bit sets when counting starts. In one setting, software's start-of-message strobe starts the count. In the other, the count starts by itself at the end of every frame, whether sent or received. While counting, a low level on the bus restarts the count from zero.

Top module: `sft_idle_timer`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `bus_free` is 0.
- R2: For a code n from 1 to 7, `bus_free` goes to 1 on the clock edge that samples the (2n−1)-th `half_tick` after the trigger, provided the bus stays high. Code 1 needs 1 tick and code 7 needs 13.
- R3: With code 0 and `retry` = 0, `bus_free` rises after DFLT_NEW_HALVES ticks (14 by default).
- R4: With code 0 and `retry` = 1, `bus_free` rises after DFLT_RETRY_HALVES ticks (6 by default).
- R5: When `start_on_end` = 0, a pulse on `som_req` starts the count from zero. A pulse on `eom_pulse` starts nothing, and while the block is idle, ticks never raise `bus_free`.
- R6: When `start_on_end` = 1, a pulse on `eom_pulse` starts the count from zero. A pulse on `som_req` starts no count and returns the block to idle.
- R7: While the block is counting, any cycle with `bus_low` = 1 resets the count to zero. After that, the full number of ticks is needed again.
- R8: Once `bus_free` is 1, it stays 1 until `bus_low` is seen, a message start (`som_req`) is seen, or, in end-triggered mode, `eom_pulse` restarts the count. It drops on the edge that samples that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sft_code | input | 3 | Idle-time code; 0 selects the default |
| start_on_end | input | 1 | 0: the count starts on `som_req`; 1: the count starts on `eom_pulse` |
| retry | input | 1 | For code 0, selects the retransmission default |
| half_tick | input | 1 | One-cycle pulse every half nominal bit period |
| som_req | input | 1 | Start-of-message strobe from software |
| eom_pulse | input | 1 | End of a sent or received frame |
| bus_low | input | 1 | The bus line is currently low (bus active) |
| bus_free | output | 1 | The required idle time has passed |

## Verification
The bench measures how many ticks pass between the trigger and `bus_free` for every code, with `retry` low and high. This distinguishes the 2n−1 rule from its off-by-one variants and checks that the two defaults are not swapped. Directed cases send the trigger that belongs to the other mode, to show that the start option really picks which event counts. Further cases put a bus-low pulse in the middle of a count, to show the count restarts rather than pauses. Long random runs mix ticks, bus activity, strobes and code changes, and every cycle is compared against a bench model of the rules.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic [1:0] {
    SFT_IDLE  = 2'd0,
    SFT_COUNT = 2'd1,
    SFT_FREE  = 2'd2
  } sft_state_e;

  function automatic int unsigned sft_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sft_target.sv
module sft_target #(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned DFLT_NEW   = 14,
  parameter int unsigned DFLT_RETRY = 6
) (
  input  logic [CODE_W-1:0] code,
  input  logic              retry,
  output logic [CNT_W-1:0]  target
);
  // Non-zero code n -> 2n-1 half periods; code 0 -> parameter defaults.
  always_comb begin
    if (code == '0) begin
      target = retry ? CNT_W'(DFLT_RETRY) : CNT_W'(DFLT_NEW);
    end else begin
      target = CNT_W'({code, 1'b0}) - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sft_trigger.sv
module sft_trigger (
  input  logic start_on_end,
  input  logic som_req,
  input  logic eom_pulse,
  output logic start_cnt,
  output logic cancel
);
  // The start option picks the event that launches the count; in
  // end-triggered mode a message start withdraws the qualifier instead.
  always_comb begin
    if (start_on_end) begin
      start_cnt = eom_pulse;
      cancel    = som_req & ~eom_pulse;
    end else begin
      start_cnt = som_req;
      cancel    = 1'b0;
    end
  end
endmodule

// File: rtl/sft_counter.sv
module sft_counter
  import sft_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cnt,
  input  logic             cancel,
  input  logic             half_tick,
  input  logic             bus_low,
  input  logic [CNT_W-1:0] target,
  output logic             bus_free
);
  sft_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (start_cnt) begin
      state_d = SFT_COUNT;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (cancel) begin
      state_d = SFT_IDLE;
    end else begin
      unique case (state_q)
        SFT_COUNT: begin
          if (bus_low) begin
            cnt_d  = '0;
            cnt_en = 1'b1;
          end else if (half_tick) begin
            cnt_d  = cnt_inc;
            cnt_en = 1'b1;
            if (cnt_inc >= target) state_d = SFT_FREE;
          end
        end
        SFT_FREE: begin
          if (bus_low) state_d = SFT_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SFT_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign bus_free = (state_q == SFT_FREE);
endmodule

// File: rtl/sft_idle_timer.sv
module sft_idle_timer
  import sft_pkg::*;
#(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned DFLT_NEW   = 14,
  parameter int unsigned DFLT_RETRY = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sft_code,
  input  logic              start_on_end,
  input  logic              retry,
  input  logic              half_tick,
  input  logic              som_req,
  input  logic              eom_pulse,
  input  logic              bus_low,
  output logic              bus_free
);
  localparam int unsigned MAX_CODE_HALVES = 2 * ((1 << CODE_W) - 1) - 1;
  localparam int unsigned MAX_HALVES = sft_max3(MAX_CODE_HALVES, DFLT_NEW, DFLT_RETRY);
  localparam int unsigned CNT_W = $clog2(MAX_HALVES + 1);

  logic [CNT_W-1:0] target;
  logic             start_cnt;
  logic             cancel;

  sft_target #(
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W),
    .DFLT_NEW  (DFLT_NEW),
    .DFLT_RETRY(DFLT_RETRY)
  ) u_target (
    .code  (sft_code),
    .retry (retry),
    .target(target)
  );

  sft_trigger u_trigger (
    .start_on_end(start_on_end),
    .som_req     (som_req),
    .eom_pulse   (eom_pulse),
    .start_cnt   (start_cnt),
    .cancel      (cancel)
  );

  sft_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_cnt(start_cnt),
    .cancel   (cancel),
    .half_tick(half_tick),
    .bus_low  (bus_low),
    .target   (target),
    .bus_free (bus_free)
  );
endmodule

// File: rtl/sft_idle_timer_chk.sv
module sft_idle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic start_on_end,
  input logic half_tick,
  input logic som_req,
  input logic eom_pulse,
  input logic bus_low,
  input logic bus_free
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!bus_free);
    end
  end

  // R2
  tick_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> $past(half_tick));

  // R7
  quiet_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> !$past(bus_low));

  // R8
  low_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free && bus_low |=> !bus_free);

  // R8
  som_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free && som_req |=> !bus_free);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free && !bus_low && !som_req && !(start_on_end && eom_pulse) |=> bus_free);
endmodule

bind sft_idle_timer sft_idle_timer_chk u_chk (.*);

// File: tb/sft_idle_timer_test.sv
module sft_idle_timer_test;
  localparam int unsigned NEW_H = 14;
  localparam int unsigned RTY_H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sft_code = 3'd0;
  logic       start_on_end = 1'b0;
  logic       retry = 1'b0;
  logic       half_tick = 1'b0;
  logic       som_req = 1'b0;
  logic       eom_pulse = 1'b0;
  logic       bus_low = 1'b0;
  logic       bus_free;

  int tests = 0;
  int fails = 0;
  int mst = 0;
  int mcnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sft_idle_timer uut (
    .clk(clk), .rst_n(rst_n), .sft_code(sft_code), .start_on_end(start_on_end),
    .retry(retry), .half_tick(half_tick), .som_req(som_req), .eom_pulse(eom_pulse),
    .bus_low(bus_low), .bus_free(bus_free)
  );

  function automatic int halves(int code, bit rt);
    if (code == 0) return rt ? RTY_H : NEW_H;
    return 2 * code - 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(bit som, bit eom, bit tick, bit low, string tag);
    bit trig;
    som_req = som; eom_pulse = eom; half_tick = tick; bus_low = low;
    @(posedge clk);
    trig = start_on_end ? eom : som;
    if (trig) begin
      mst = 1; mcnt = 0;
    end else if (start_on_end && som) begin
      mst = 0;
    end else if (mst == 1) begin
      if (low) mcnt = 0;
      else if (tick) begin
        mcnt++;
        if (mcnt >= halves(int'(sft_code), retry)) mst = 2;
      end
    end else if (mst == 2 && low) begin
      mst = 0;
    end
    @(negedge clk);
    check(tag, int'(bus_free), (mst == 2) ? 1 : 0);
  endtask

  // trigger, then count ticks until bus_free rises
  task automatic measure(int code, bit rt, bit opt, string tag);
    int n;
    sft_code = 3'(code); retry = rt; start_on_end = opt;
    step(!opt, opt, 1'b0, 1'b0, tag);
    n = 0;
    for (int i = 0; i < 40 && !bus_free; i++) begin
      step(1'b0, 1'b0, 1'b1, 1'b0, tag);
      n++;
    end
    check(tag, n, halves(code, rt));
    step(1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    check("R1", int'(bus_free), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(bus_free), 0);

    // R2: every non-zero code, som-triggered
    for (int c = 1; c < 8; c++) measure(c, 1'b0, 1'b0, "R2");
    // R3 / R4: defaults
    measure(0, 1'b0, 1'b0, "R3");
    measure(0, 1'b1, 1'b0, "R4");
    measure(0, 1'b1, 1'b1, "R4");
    // R6: end-triggered mode
    measure(3, 1'b0, 1'b1, "R6");

    // R5: eom and ticks without a trigger do nothing in som mode
    start_on_end = 1'b0; sft_code = 3'd1;
    step(1'b0, 1'b1, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
    check("R5", int'(bus_free), 0);

    // R6: som in end mode starts no count and cancels bus_free
    start_on_end = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
    check("R6", int'(bus_free), 0);
    step(1'b0, 1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R6");
    check("R6", int'(bus_free), 1);
    step(1'b1, 1'b0, 1'b0, 1'b0, "R6");
    check("R6", int'(bus_free), 0);

    // R7: bus low midway restarts from zero (code 3 -> 5 ticks)
    start_on_end = 1'b0; sft_code = 3'd3; retry = 1'b0;
    step(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R7");
    check("R7", int'(bus_free), 0);
    step(1'b0, 1'b0, 1'b1, 1'b0, "R7");
    check("R7", int'(bus_free), 1);

    // R8: hold while quiet, drop on bus activity
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, 1'b0, "R8");
    check("R8", int'(bus_free), 1);
    step(1'b0, 1'b0, 1'b0, 1'b1, "R8");
    check("R8", int'(bus_free), 0);

    // random mix, checked each cycle against the model
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 99) < 3) sft_code = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 99) < 2) start_on_end = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 5) retry = 1'($urandom_range(0, 1));
      step($urandom_range(0, 99) < 4, $urandom_range(0, 99) < 4,
           $urandom_range(0, 99) < 45, $urandom_range(0, 99) < 4, "R2 R6 R7 R8");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule